// File: doc/BRIEF.md
# Twin Timer/Counter

This block is a register-mapped peripheral with two independent 32-bit timer/counter channels. Each channel owns three words: a control/status word, a load word and a live count word. Software picks the count direction, may preload the count from the load word, and may have the channel reload itself each time it rolls over. Otherwise the channel stops after its first rollover. A rollover sets a sticky status bit. Software clears that bit by writing a one to it.

The register bus is a plain single-cycle word interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`, and reading has no side effect. There is no handshake and no back-pressure: every access completes in the cycle it is presented. Both channel interrupts are ORed onto one level output, `irq`. Reading the count word of an up-counting channel with its interrupt masked gives a free-running time base.

Word addresses select the channel in bit 2 and the register in bits 1:0:
- 0: control
- 1: load
- 2: count
- 3: unused, reads zero

Channel 1 occupies words 4 to 7.

Top module: `twin_timer`

## Requirements
- R1: After reset, every readable word and `irq` are zero.
- R2: Control word bits are: 0 mode, 1 down, 2 generate, 3 capture, 4 auto-reload, 5 load, 6 interrupt enable, 7 run, 8 status, 9 pwm, 10 all-enable. Bits 0, 2, 3, 9 and 10 read back as written and have no effect on counting. Bits 31:11 read zero. Word offset 3 of each channel reads zero and ignores writes.
- R3: While the load bit (bit 5) is set, the count is copied from the load word on every cycle and does not step, whatever the run bit says.
- R4: With run (bit 7) set and load clear, the count steps by one each cycle: down when bit 1 is 1, up when bit 1 is 0.
- R5: A step past 0 going down, or past 0xFFFFFFFF going up, is a rollover and sets status (bit 8). With auto-reload (bit 4) set, the count takes the load word on that same edge and keeps counting.
- R6: On a rollover with auto-reload clear, the count holds its terminal value (0 or 0xFFFFFFFF) and the run bit clears.
- R7: Writing 1 to status clears it, and writing 0 leaves it unchanged, so writing back a value just read acknowledges the interrupt. If a rollover and a clearing write meet in one cycle, status ends set.
- R8: `irq` is high exactly while some channel has both status and interrupt enable (bit 6) set.
- R9: With run and load both clear, the count keeps its value.
- R10: The count word is read-only. Writes to it leave the count unchanged.
- R11: Activity in one channel leaves the other channel's words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 3 | Word address: bit 2 selects the channel, bits 1:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the two channel interrupts |

## Verification
The hardest case to reach from the ports is a clearing write to the status bit that lands on the same edge as a rollover. The count moves on its own while the write is in flight, so the bench starts from a known preload, counts every edge the write sequence takes, and issues the acknowledge so that its write edge is the edge where the count leaves zero. The masked-interrupt case and the acknowledge by write-back are reached the same way on the auto-reloading channel. The one-shot stop is reached with a preload a few steps from the top of the count range.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned CTRL_W   = 11;
  localparam int unsigned B_MODE   = 0;
  localparam int unsigned B_DOWN   = 1;
  localparam int unsigned B_GEN    = 2;
  localparam int unsigned B_CAPT   = 3;
  localparam int unsigned B_AUTO   = 4;
  localparam int unsigned B_LOAD   = 5;
  localparam int unsigned B_IEN    = 6;
  localparam int unsigned B_RUN    = 7;
  localparam int unsigned B_STAT   = 8;
  localparam int unsigned B_PWM    = 9;
  localparam int unsigned B_ALL    = 10;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              roll,
  input  logic              halt,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CTRL_W-1:0] ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_en) begin
      ctrl_nxt = wdata;
      ctrl_nxt[B_STAT] = ctrl[B_STAT] & ~wdata[B_STAT];
    end
    if (roll) ctrl_nxt[B_STAT] = 1'b1;
    if (halt) ctrl_nxt[B_RUN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nxt;
  end

  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_STAT] && !roll) |=> !ctrl[B_STAT]);
  assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[B_STAT] && ctrl[B_STAT]) |=> ctrl[B_STAT]);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> ctrl[B_STAT]);
  assert_halt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !ctrl[B_RUN]);
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] load_val,
  input  logic         hold,
  input  logic         run,
  input  logic         down,
  input  logic         auto_rl,
  output logic [W-1:0] cnt,
  output logic         roll,
  output logic         halt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic step, terminal;
  logic [W-1:0] cnt_nxt;

  assign terminal = down ? (cnt == '0) : (&cnt);
  assign step     = run & ~hold;
  assign roll     = step & terminal;
  assign halt     = roll & ~auto_rl;

  always_comb begin
    cnt_nxt = cnt;
    if (hold)         cnt_nxt = load_val;
    else if (roll)    cnt_nxt = auto_rl ? load_val : cnt;
    else if (step)    cnt_nxt = down ? cnt - ONE : cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt == $past(load_val));
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> $stable(cnt));
  assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && down && cnt != '0) |=> cnt == $past(cnt) - ONE);
  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && !down && !(&cnt)) |=> cnt == $past(cnt) + ONE);
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && auto_rl) |=> cnt == $past(load_val));
  assert_hold_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cnt));
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic         wr_load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_word,
  output logic [W-1:0] load_word,
  output logic [W-1:0] cnt_word,
  output logic         irq
);
  logic [CTRL_W-1:0] ctrl;
  logic              roll, halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_word <= '0;
    else if (wr_load) load_word <= wdata;
  end

  tmr_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ctrl),
    .wdata (wdata[CTRL_W-1:0]),
    .roll  (roll),
    .halt  (halt),
    .ctrl  (ctrl)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_val (load_word),
    .hold     (ctrl[B_LOAD]),
    .run      (ctrl[B_RUN]),
    .down     (ctrl[B_DOWN]),
    .auto_rl  (ctrl[B_AUTO]),
    .cnt      (cnt_word),
    .roll     (roll),
    .halt     (halt)
  );

  assign ctrl_word = {{(W-CTRL_W){1'b0}}, ctrl};
  assign irq       = ctrl[B_STAT] & ctrl[B_IEN];
endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 2,
  localparam int unsigned CH_BITS = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned ADDR_W  = CH_BITS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CH_BITS-1:0] ch_idx;
  reg_sel_e           sel;
  logic [DATA_W-1:0]  ctrl_a [N_CH];
  logic [DATA_W-1:0]  load_a [N_CH];
  logic [DATA_W-1:0]  cnt_a  [N_CH];
  logic [N_CH-1:0]    irq_v;

  assign ch_idx = bus_addr[ADDR_W-1:2];
  assign sel    = reg_sel_e'(bus_addr[1:0]);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (ch_idx == CH_BITS'(g));
    tmr_channel #(.W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && sel == SEL_CTRL),
      .wr_load   (hit && sel == SEL_LOAD),
      .wdata     (bus_wdata),
      .ctrl_word (ctrl_a[g]),
      .load_word (load_a[g]),
      .cnt_word  (cnt_a[g]),
      .irq       (irq_v[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_idx == CH_BITS'(c)) begin
        case (sel)
          SEL_CTRL: bus_rdata = ctrl_a[c];
          SEL_LOAD: bus_rdata = load_a[c];
          SEL_CNT:  bus_rdata = cnt_a[c];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq = |irq_v;

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));
  assert_gap_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/twin_timer_tb.sv
`timescale 1ns/1ps
module twin_timer_tb;
  localparam int AW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  twin_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [3:0]  idle;
    logic [2:0]  ra;
    logic [31:0] exp_v;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{3'd1, 32'd20,      4'd0, 3'd1, 32'd20,    4'd2},  // R2 load word readback
    '{3'd0, 32'h020,     4'd1, 3'd2, 32'd20,    4'd3},  // R3 preload
    '{3'd0, 32'h0A2,     4'd3, 3'd2, 32'd20,    4'd3},  // R3 load blocks run
    '{3'd0, 32'h082,     4'd2, 3'd2, 32'd18,    4'd4},  // R4 down steps
    '{3'd2, 32'h77,      4'd0, 3'd2, 32'd16,    4'd10}, // R10 count write ignored
    '{3'd0, 32'h002,     4'd4, 3'd2, 32'd14,    4'd9},  // R9 run cleared freezes
    '{3'd0, 32'h70D,     4'd2, 3'd0, 32'h60D,   4'd2},  // R2 inert bits read back
    '{3'd0, 32'h68D,     4'd3, 3'd2, 32'd17,    4'd2}   // R2 inert bits, R4 up
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp_v);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp_v);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) chk_rd("R1 reset word", AW'(a), 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // vector table, channel 0
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i].wa, TBL[i].wd);
      tick(int'(TBL[i].idle));
      rd(TBL[i].ra, rv);
      n_chk++;
      if (rv !== TBL[i].exp_v) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", TBL[i].req, i, rv, TBL[i].exp_v);
      end
    end

    // channel 1 auto-reload down, period 4 (R5, R8, R11)
    wr(3'd5, 32'd3);
    wr(3'd4, 32'h020);
    tick(1);
    wr(3'd4, 32'h0D2);
    chk_rd("R3 ch1 preloaded", 3'd6, 32'd3);
    tick(3);
    chk_rd("R4 ch1 reaches zero", 3'd6, 32'd0);
    chk("R8 irq before rollover", {31'b0, irq}, 32'h0);
    tick(1);
    chk_rd("R5 reload on rollover", 3'd6, 32'd3);
    chk_rd("R5 status set", 3'd4, 32'h1D2);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    chk_rd("R11 ch0 ctrl untouched", 3'd0, 32'h68D);
    tick(4);
    chk_rd("R5 periodic reload", 3'd6, 32'd3);

    // R7 acknowledge by write-back
    wr(3'd4, 32'h1D2);
    chk_rd("R7 write-back clears", 3'd4, 32'h0D2);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);
    tick(2);
    wr(3'd4, 32'h0D2);
    chk_rd("R7 zero keeps status", 3'd4, 32'h1D2);
    // clear write lands on rollover edge: set wins
    wr(3'd4, 32'h1D2);
    chk_rd("R7 set wins", 3'd4, 32'h1D2);
    chk_rd("R5 reload at collision", 3'd6, 32'd3);
    wr(3'd4, 32'h1D2);
    chk_rd("R7 ack", 3'd4, 32'h0D2);

    // R8 masking
    wr(3'd4, 32'h092);
    chk_rd("R8 status while masked", 3'd4, 32'h192);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h0D2);
    chk("R8 unmask raises irq", {31'b0, irq}, 32'h1);

    // stop channel 1
    tick(1);
    wr(3'd4, 32'h100);
    chk_rd("R7 stop and clear", 3'd4, 32'h0);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);
    tick(3);
    chk_rd("R9 ch1 frozen", 3'd6, 32'd2);

    // R6 one-shot up on channel 0
    wr(3'd1, 32'hFFFF_FFFD);
    wr(3'd0, 32'h020);
    tick(1);
    wr(3'd0, 32'h0C0);
    tick(2);
    chk_rd("R4 up near top", 3'd2, 32'hFFFF_FFFF);
    chk_rd("R6 still running", 3'd0, 32'h0C0);
    tick(1);
    chk_rd("R6 run cleared", 3'd0, 32'h140);
    chk("R8 irq from ch0", {31'b0, irq}, 32'h1);
    tick(3);
    chk_rd("R6 holds top", 3'd2, 32'hFFFF_FFFF);

    // R6 one-shot down on channel 0
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h122);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    tick(1);
    wr(3'd0, 32'h082);
    tick(2);
    chk_rd("R4 down to zero", 3'd2, 32'd0);
    tick(1);
    chk_rd("R6 down stop ctrl", 3'd0, 32'h102);
    tick(2);
    chk_rd("R6 holds zero", 3'd2, 32'd0);
    chk("R8 masked after stop", {31'b0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule